// File: doc/BRIEF.md
# Output Compare Timer Channel

This block is a 16-bit compare channel with a private up-counter and one output pin. The counter advances on a clock-enable tick and is tested each tick against two compare registers, a primary and a secondary. Depending on the control inputs, the pin carries either a repeating pulse-width waveform or one pulse that is armed again by a strobe. A hit on either register also produces a one-cycle match pulse.

A 5-bit source select picks one line from a vector of event sources. With the select at zero the counter runs freely. With a non-zero select, the event either clears the counter (synchronous mode) or releases a counter held at rest (trigger mode). Two instances can be joined into a 32-bit channel. The low instance passes a carry and its equality flags to the high instance, and the high instance passes its equality flags back, so that both halves act on a full 32-bit match.

Top module: `ocmp_channel`

## Requirements
- R1: With select 0 and enable high, the count rises by one on each cycle with tick high and holds when tick is low. It wraps from 0xFFFF to 0x0000. With enable low, the count, pin and match pulse go to 0 at the next edge.
- R2: match_pulse is high for exactly the cycle after a tick on which the running count equals the primary or the secondary register.
- R3: Select value s (1..31) takes src_vec bit s as the event; bit 0 is never an event source. trig_mode=1 selects trigger mode and trig_mode=0 selects synchronous mode. Events on lines that are not selected have no effect.
- R4: In synchronous mode the counter runs from enable. A selected event forces the count to 0 at the next edge, even when tick is high in that cycle. A compare hit on the count in that cycle still acts.
- R5: In trigger mode the count holds until a selected event. It counts from the next cycle on, and later events change nothing. A rearm strobe puts the counter back on hold.
- R6: With pwm_mode=1 the pin goes high after a tick that hits the primary register and low after a tick that hits the secondary register, and the secondary wins on a tie. The count restarts at 0 after a secondary hit.
- R7: With pwm_mode=0 the pin goes high on a primary hit and low on a later secondary hit. It then stays low on all further hits until rearm pulses.
- R8: With pair_en set in both instances, the high instance advances only on the carry from a wrap of the low instance. The compare hits only when the full 32-bit count equals {high register, low register}.
- R9: A synchronous active-high reset clears the count, the pin, the match pulse and the hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low clears the channel |
| tick | input | 1 | Count enable from the chosen time base |
| src_vec | input | 32 | Sync/trigger event lines; bit s goes with select s |
| src_sel | input | 5 | Event source select; 0 means free-running |
| trig_mode | input | 1 | 1 = trigger (hold until event), 0 = synchronous clear |
| pwm_mode | input | 1 | 1 = continuous waveform, 0 = single pulse |
| rearm | input | 1 | Strobe that re-arms single pulse and trigger hold |
| pair_en | input | 1 | Join with the neighbour instance into 32 bits |
| is_high | input | 1 | This instance is the upper half of a pair |
| cmp_pri | input | 16 | Primary compare value (rising edge) |
| cmp_sec | input | 16 | Secondary compare value (falling edge) |
| carry_in | input | 1 | Carry from the low half (used by the upper half) |
| peer_eq_pri | input | 1 | Primary equality flag of the other half |
| peer_eq_sec | input | 1 | Secondary equality flag of the other half |
| carry_out | output | 1 | Counter wraps on this tick |
| eq_pri_out | output | 1 | Own count equals cmp_pri |
| eq_sec_out | output | 1 | Own count equals cmp_sec |
| count | output | 16 | Current counter value |
| oc_pin | output | 1 | Compare output pin |
| match_pulse | output | 1 | One-cycle compare hit indication |

## Verification
A selected synchronous event and a compare hit can land on the same tick. The clear then takes the count to zero while the hit on the old count still moves the pin. The bench fires the sync line on the tick where the count equals the secondary register in single-pulse mode. It expects the pin to fall, a match pulse, a zero count, and no new rise from the restarted count until rearm. A second coincidence, primary equal to secondary in waveform mode, is judged by the pin staying low while match pulses and restarts continue.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [1:0] {
    CM_FREE = 2'd0,
    CM_SYNC = 2'd1,
    CM_TRIG = 2'd2
  } cnt_mode_e;
endpackage

// File: rtl/ocmp_srcsel.sv
module ocmp_srcsel
  import ocmp_pkg::*;
#(
  parameter int SELW = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   rearm,
  input  logic [(1<<SELW)-1:0]   src_vec,
  input  logic [SELW-1:0]        src_sel,
  input  logic                   trig_mode,
  output cnt_mode_e              mode,
  output logic                   run,
  output logic                   sync_clr
);
  logic evt;
  logic trig_ok;

  always_comb begin
    evt = (src_sel != '0) && src_vec[src_sel];
    if (src_sel == '0)  mode = CM_FREE;
    else if (trig_mode) mode = CM_TRIG;
    else                mode = CM_SYNC;
    run      = en && ((mode != CM_TRIG) || trig_ok);
    sync_clr = en && (mode == CM_SYNC) && evt;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || rearm)              trig_ok <= 1'b0;
    else if (mode == CM_TRIG && evt)      trig_ok <= 1'b1;
  end

  // R5: a selected event in trigger mode releases the counter next cycle
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (en && mode == CM_TRIG && evt && !rearm) |=> (!en || run));
endmodule

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         run,
  input  logic         tick,
  input  logic         sync_clr,
  input  logic         pwm_clr,
  input  logic         pair_hi,
  input  logic         carry_in,
  output logic [W-1:0] cnt,
  output logic         carry_out
);
  localparam logic [W-1:0] CMAX = '1;
  logic step;

  always_comb begin
    step      = pair_hi ? carry_in : tick;
    carry_out = en && run && tick && !sync_clr && !pwm_clr && (cnt == CMAX);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)          cnt <= '0;
    else if (sync_clr)       cnt <= '0;
    else if (run && pwm_clr) cnt <= '0;
    else if (run && step)    cnt <= cnt + 1'b1;
  end

  // R1: a plain tick advances the count by one, wrapping at the top
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (en && run && tick && !pair_hi && !sync_clr && !pwm_clr)
      |=> (cnt == W'($past(cnt) + 1'b1)));
  // R8: the upper half advances on the carry from the lower half
  a_r8_carry: assert property (@(posedge clk) disable iff (rst)
    (en && run && pair_hi && carry_in && !sync_clr && !pwm_clr)
      |=> (cnt == W'($past(cnt) + 1'b1)));
  // R4: a synchronous event leaves a zero count
  a_r4_sync_zero: assert property (@(posedge clk) disable iff (rst)
    sync_clr |=> (cnt == '0));
endmodule

// File: rtl/ocmp_wave.sv
module ocmp_wave (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic run,
  input  logic tick,
  input  logic pwm_mode,
  input  logic rearm,
  input  logic m_pri,
  input  logic m_sec,
  output logic pin,
  output logic pulse
);
  logic hit;
  logic done;

  always_comb hit = en && run && tick;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pin   <= 1'b0;
      pulse <= 1'b0;
      done  <= 1'b0;
    end else begin
      pulse <= hit && (m_pri || m_sec);
      if (pwm_mode || rearm) done <= 1'b0;
      if (hit) begin
        if (pwm_mode) begin
          if (m_sec)      pin <= 1'b0;
          else if (m_pri) pin <= 1'b1;
        end else begin
          if (m_sec && pin) begin
            pin  <= 1'b0;
            done <= 1'b1;
          end else if (m_pri && !m_sec && !done) begin
            pin  <= 1'b1;
          end
        end
      end
    end
  end

  // R6: a secondary hit in waveform mode always leaves the pin low
  a_r6_sec_low: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && hit && m_sec) |=> !pin);
  // R7: once the single pulse has ended the pin stays low
  a_r7_one_shot: assert property (@(posedge clk) disable iff (rst)
    (done && !pwm_mode) |-> !pin);
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int W    = 16,
  parameter int SELW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 tick,
  input  logic [(1<<SELW)-1:0] src_vec,
  input  logic [SELW-1:0]      src_sel,
  input  logic                 trig_mode,
  input  logic                 pwm_mode,
  input  logic                 rearm,
  input  logic                 pair_en,
  input  logic                 is_high,
  input  logic [W-1:0]         cmp_pri,
  input  logic [W-1:0]         cmp_sec,
  input  logic                 carry_in,
  input  logic                 peer_eq_pri,
  input  logic                 peer_eq_sec,
  output logic                 carry_out,
  output logic                 eq_pri_out,
  output logic                 eq_sec_out,
  output logic [W-1:0]         count,
  output logic                 oc_pin,
  output logic                 match_pulse
);
  cnt_mode_e mode;
  logic run, sync_clr, m_pri, m_sec, pwm_clr, pair_hi;

  ocmp_srcsel #(.SELW(SELW)) u_src (
    .clk(clk), .rst(rst), .en(en), .rearm(rearm),
    .src_vec(src_vec), .src_sel(src_sel), .trig_mode(trig_mode),
    .mode(mode), .run(run), .sync_clr(sync_clr)
  );

  always_comb begin
    eq_pri_out = (count == cmp_pri);
    eq_sec_out = (count == cmp_sec);
    m_pri      = eq_pri_out && (!pair_en || peer_eq_pri);
    m_sec      = eq_sec_out && (!pair_en || peer_eq_sec);
    pwm_clr    = pwm_mode && tick && m_sec;
    pair_hi    = pair_en && is_high;
  end

  ocmp_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .run(run), .tick(tick),
    .sync_clr(sync_clr), .pwm_clr(pwm_clr), .pair_hi(pair_hi),
    .carry_in(carry_in), .cnt(count), .carry_out(carry_out)
  );

  ocmp_wave u_wave (
    .clk(clk), .rst(rst), .en(en), .run(run), .tick(tick),
    .pwm_mode(pwm_mode), .rearm(rearm), .m_pri(m_pri), .m_sec(m_sec),
    .pin(oc_pin), .pulse(match_pulse)
  );

  // R5: a held counter in trigger mode does not move
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (en && mode == CM_TRIG && !run) |=> (!en || $stable(count)));
  // R9: reset leaves the channel quiet
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (count == '0 && !oc_pin && !match_pulse));
endmodule

// File: tb/test_ocmp_channel.sv
module test_ocmp_channel;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, en = 1'b0, tk = 1'b0, trg = 1'b0, pwm = 1'b0;
  logic        rearm = 1'b0, pr = 1'b0;
  logic [31:0] sv = '0;
  logic [4:0]  sel = '0;
  logic [15:0] pri = '0, sec = '0, hpri = '0, hsec = '0;

  logic        lo_co, lo_ep, lo_es, lo_pin, lo_pl;
  logic        hi_co, hi_ep, hi_es, hi_pin, hi_pl;
  logic [15:0] lo_cnt, hi_cnt;
  logic        en_hi;
  assign en_hi = en && pr;

  ocmp_channel i_ocmp_channel (
    .clk(clk), .rst(rst), .en(en), .tick(tk), .src_vec(sv), .src_sel(sel),
    .trig_mode(trg), .pwm_mode(pwm), .rearm(rearm), .pair_en(pr),
    .is_high(1'b0), .cmp_pri(pri), .cmp_sec(sec), .carry_in(1'b0),
    .peer_eq_pri(hi_ep), .peer_eq_sec(hi_es), .carry_out(lo_co),
    .eq_pri_out(lo_ep), .eq_sec_out(lo_es), .count(lo_cnt),
    .oc_pin(lo_pin), .match_pulse(lo_pl)
  );

  ocmp_channel i_ocmp_channel_hi (
    .clk(clk), .rst(rst), .en(en_hi), .tick(tk), .src_vec(sv), .src_sel(sel),
    .trig_mode(trg), .pwm_mode(pwm), .rearm(rearm), .pair_en(pr),
    .is_high(1'b1), .cmp_pri(hpri), .cmp_sec(hsec), .carry_in(lo_co),
    .peer_eq_pri(lo_ep), .peer_eq_sec(lo_es), .carry_out(hi_co),
    .eq_pri_out(hi_ep), .eq_sec_out(hi_es), .count(hi_cnt),
    .oc_pin(hi_pin), .match_pulse(hi_pl)
  );

  // scoreboard queues
  logic [31:0] q_cnt[$];
  logic        q_pin[$], q_pl[$], q_pr[$];
  string       q_tag[$];
  int          n_vec = 0, n_bad = 0;
  string       tag = "R9";
  bit          finished = 0;

  // reference state
  logic [31:0] m_cnt = '0;
  bit          m_tok = 0, m_pin = 0, m_done = 0, m_pl = 0;

  task automatic model_push();
    logic [31:0] mask, p32, s32, n_cnt;
    bit free, evt, run, hit, mp, ms, n_tok, n_pin, n_done;
    mask = pr ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    p32  = pr ? {hpri, pri} : {16'h0, pri};
    s32  = pr ? {hsec, sec} : {16'h0, sec};
    if (rst || !en) begin
      m_cnt = '0; m_tok = 0; m_pin = 0; m_done = 0; m_pl = 0;
    end else begin
      free = (sel == 0);
      evt  = !free && sv[sel];
      run  = free || !trg || m_tok;
      hit  = run && tk;
      mp   = (m_cnt == p32);
      ms   = (m_cnt == s32);
      if (!free && !trg && evt)   n_cnt = '0;
      else if (hit && pwm && ms)  n_cnt = '0;
      else if (hit)               n_cnt = (m_cnt + 1) & mask;
      else                        n_cnt = m_cnt;
      n_tok = rearm ? 0 : ((!free && trg && evt) ? 1 : m_tok);
      n_done = (pwm || rearm) ? 0 : m_done;
      n_pin = m_pin;
      if (hit) begin
        if (pwm) begin
          if (ms) n_pin = 0; else if (mp) n_pin = 1;
        end else begin
          if (ms && m_pin) begin n_pin = 0; n_done = 1; end
          else if (mp && !ms && !m_done) n_pin = 1;
        end
      end
      m_pl = hit && (mp || ms);
      m_cnt = n_cnt; m_tok = n_tok; m_pin = n_pin; m_done = n_done;
    end
    q_cnt.push_back(m_cnt); q_pin.push_back(m_pin); q_pl.push_back(m_pl);
    q_pr.push_back(pr); q_tag.push_back(tag);
  endtask

  task automatic cyc();
    model_push();
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q_cnt.size() > 0) begin
      logic [31:0] ec; logic ep, el, epr; string t; bit bad;
      ec = q_cnt.pop_front(); ep = q_pin.pop_front(); el = q_pl.pop_front();
      epr = q_pr.pop_front(); t = q_tag.pop_front();
      n_vec++;
      bad = 0;
      if (lo_cnt !== ec[15:0]) begin
        bad = 1; $display("FAIL %s count got %h exp %h", t, lo_cnt, ec[15:0]);
      end
      if (epr && hi_cnt !== ec[31:16]) begin
        bad = 1; $display("FAIL %s high count got %h exp %h", t, hi_cnt, ec[31:16]);
      end
      if (lo_pin !== ep) begin
        bad = 1; $display("FAIL %s pin got %b exp %b", t, lo_pin, ep);
      end
      if (lo_pl !== el) begin
        bad = 1; $display("FAIL %s match_pulse got %b exp %b", t, lo_pl, el);
      end
      if (bad) n_bad++;
    end
  end

  task automatic quiet();
    en = 0; tk = 0; sv = '0; rearm = 0; cyc();
    en = 1;
  endtask

  initial begin
    // R9: reset state
    tag = "R9";
    repeat (3) cyc();
    rst = 0;
    cyc();

    // R1: free run with tick gaps, then a full 16-bit wrap
    tag = "R1"; sel = 0; pwm = 0; pri = 16'h8000; sec = 16'h9000;
    quiet();
    for (int i = 0; i < 24; i++) begin tk = (i % 4 != 3); cyc(); end
    quiet(); tk = 1;
    for (int i = 0; i < 65540; i++) cyc();
    quiet();

    // R2, R6: waveform mode with sparse ticks
    tag = "R6"; pwm = 1; pri = 3; sec = 7;
    for (int i = 0; i < 40; i++) begin tk = (i % 3 != 2); cyc(); end
    // R6: tie between primary and secondary, R2 pulses still come
    tag = "R2"; quiet(); pri = 5; sec = 5;
    for (int i = 0; i < 20; i++) begin tk = 1; cyc(); end

    // R4, R7: single pulse, sync event on the secondary-hit tick, rearm
    tag = "R7"; quiet(); pwm = 0; pri = 2; sec = 5; sel = 3; trg = 0; tk = 1;
    for (int i = 0; i < 12; i++) begin
      sv = (i == 5) ? 32'h8 : 32'h0;
      tag = (i == 5) ? "R4" : "R7";
      cyc();
    end
    sv = 32'h8; tag = "R4"; cyc(); sv = '0;
    tag = "R7"; rearm = 1; cyc(); rearm = 0;
    for (int i = 0; i < 10; i++) cyc();

    // R3: unselected lines and bit 0 do nothing in sync mode
    tag = "R3"; quiet(); pwm = 1; pri = 2; sec = 6; sel = 9; tk = 1;
    for (int i = 0; i < 16; i++) begin sv = 32'hFFFF_FDFF; cyc(); end
    sv = 32'h200; cyc(); sv = '0;
    sel = 0; sv = '1;
    for (int i = 0; i < 8; i++) cyc();
    sv = '0;

    // R5: trigger hold, release, ignored events, rearm
    tag = "R5"; quiet(); sel = 7; trg = 1; pwm = 1; pri = 2; sec = 4; tk = 1;
    for (int i = 0; i < 6; i++) begin sv = 32'h40; cyc(); end
    sv = 32'h80; cyc(); sv = '0;
    for (int i = 0; i < 14; i++) begin sv = (i % 5 == 0) ? 32'h80 : 32'h0; cyc(); end
    sv = '0; rearm = 1; cyc(); rearm = 0;
    for (int i = 0; i < 5; i++) cyc();
    trg = 0; sel = 0;

    // R8: 32-bit pair, single pulse at 0x0001_0002..0x0001_0005
    tag = "R8"; quiet(); en = 0; pr = 1; cyc(); en = 1;
    pwm = 0; pri = 2; sec = 5; hpri = 1; hsec = 1; tk = 1;
    for (int i = 0; i < 65550; i++) cyc();
    pr = 0; quiet();

    @(posedge clk); #4;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule